// File: doc/BRIEF.md
# Inertial Sensor Register Sequencer

This block sits between a controller and an inertial sensor on a four-wire serial link. It carries out single 16-bit register reads and writes, and it runs the power-up bring-up sequence. The controller sees a small command port (read or write, an 8-bit register address, 16 bits of write data) and a busy flag. A one-cycle done pulse marks the end of every command and the end of bring-up. The block drives the sensor's active-low hardware reset, its chip select, its serial clock and its data input, and it samples the sensor's data output.

A read takes two frames. The first carries the address and the second clocks out zeros while it captures the result. A write is split into two byte frames, low byte first, sent to the given address and then to the next one. After every frame, chip select goes high for a stall gap. Bring-up pulses the reset line and waits for the sensor to settle. It then checks the identity register and repeats the reset until the identity matches. Next it runs a self-test until the failure flag clears, writes zero to the filter and decimation registers, and waits a short settling time before it reports completion. All waits are counted in clock cycles derived from the clock-frequency parameter.

Top module: `imu_regseq`

## Requirements
- R1: After reset, the sensor reset line, chip select and serial clock are all high, and busy and done are low.
- R2: A read of address A sends the frame {A, 8'h00} and then the frame 16'h0000. The clock idles high, the data-out line changes on falling clock edges, data-in is sampled on rising edges, and bits go most significant first. rdata holds the 16 bits captured during the second frame.
- R3: A write of D to address A sends {1'b1, A[6:0], D[7:0]} and then {1'b1, (A+1)[6:0], D[15:8]}.
- R4: Every frame, including the last frame of a command, is followed by chip select high for at least STALL_US microseconds before the next frame starts or the command completes.
- R5: Chip select is low for at least CS_SETUP_US microseconds before the first falling clock edge of a frame.
- R6: Bring-up holds the sensor reset line low for exactly RST_LOW_US microseconds. No frame starts during the RST_WAIT_US microseconds after the line is released.
- R7: Bring-up reads address 0x72. If the result is not 0x4079, the reset pulse and the read are repeated.
- R8: Self-test writes 0x0004 to address 0x68. At least STALL_US+SELFTEST_US microseconds after the last frame of that write, it reads address 0x02. If bit 5 of the result is set, the self-test write is repeated.
- R9: Configuration writes zero to address 0x5C and then to address 0x64. The done pulse follows at least STALL_US+CFG_WAIT_US microseconds after the last frame.
- R10: done lasts one cycle, and busy is low in that cycle. A command presented while busy is high is ignored and sends no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_req | input | 1 | Starts the bring-up sequence (sampled when idle) |
| cmd_valid | input | 1 | Command request (sampled when idle) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 8 | Register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | A command or the bring-up is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Result of the last read command |
| sen_rst_n | output | 1 | Sensor hardware reset, active low |
| sen_cs_n | output | 1 | Sensor chip select, active low |
| sen_sclk | output | 1 | Serial clock, idles high |
| sen_mosi | output | 1 | Serial data to the sensor |
| sen_miso | input | 1 | Serial data from the sensor |

## Verification
The assertions assume that the controller raises boot_req or cmd_valid only while busy is low, and that the serial clock half-period and all wait parameters come to at least one cycle. The bench stays within this. It issues each request as a single-cycle pulse while the block is idle. The one exception is the deliberate overlap test, which holds a second command while busy is high and then drops it before completion. The bench's sensor model answers the identity read and the status read wrongly exactly once each, so that both retry loops run. It also keeps a byte-wide register image, so writes can be read back through the command port.

// File: rtl/regseq_pkg.sv
package regseq_pkg;
  localparam logic [7:0]  ADDR_PROD_ID   = 8'h72;
  localparam logic [7:0]  ADDR_GLOBAL    = 8'h68;
  localparam logic [7:0]  ADDR_STATUS    = 8'h02;
  localparam logic [7:0]  ADDR_FILTER    = 8'h5C;
  localparam logic [7:0]  ADDR_DECIM     = 8'h64;
  localparam logic [15:0] PROD_ID_VALUE  = 16'h4079;
  localparam logic [15:0] SELFTEST_WORD  = 16'h0004;
  localparam int          SELFTEST_FAIL  = 5;

  typedef enum logic [1:0] {F_IDLE, F_SETUP, F_LOW, F_HIGH} frame_state_t;
  typedef enum logic [2:0] {A_IDLE, A_F1, A_G1, A_F2, A_G2} acc_state_t;
  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_RLO, S_RWAIT, S_ID, S_STW, S_STWAIT, S_STRD,
    S_CFG1, S_CFG2, S_CFGWAIT
  } seq_state_t;
endpackage

// File: rtl/regseq_frame.sv
module regseq_frame #(
  parameter int HALF    = 50,
  parameter int SETUP_T = 100
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [15:0] tx,
  output logic        done,
  output logic [15:0] rx,
  output logic        cs_n,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  import regseq_pkg::*;
  localparam int CMAX = (HALF > SETUP_T) ? HALF : SETUP_T;
  localparam int CW   = $clog2(CMAX + 1);

  frame_state_t   st;
  logic [CW-1:0]  cnt;
  logic [15:0]    sh;
  logic [3:0]     nbit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= F_IDLE; cs_n <= 1'b1; sclk <= 1'b1; mosi <= 1'b0;
      done <= 1'b0; rx <= '0; sh <= '0; cnt <= '0; nbit <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        F_IDLE: if (start) begin
          sh <= tx; cs_n <= 1'b0; nbit <= '0;
          cnt <= CW'(SETUP_T - 1); st <= F_SETUP;
        end
        F_SETUP: if (cnt == '0) begin
          sclk <= 1'b0; mosi <= sh[15]; cnt <= CW'(HALF - 1); st <= F_LOW;
        end else cnt <= cnt - 1'b1;
        F_LOW: if (cnt == '0) begin
          sclk <= 1'b1; rx <= {rx[14:0], miso}; sh <= {sh[14:0], 1'b0};
          cnt <= CW'(HALF - 1); st <= F_HIGH;
        end else cnt <= cnt - 1'b1;
        F_HIGH: if (cnt == '0) begin
          if (nbit == 4'd15) begin
            cs_n <= 1'b1; done <= 1'b1; st <= F_IDLE;
          end else begin
            nbit <= nbit + 1'b1; sclk <= 1'b0; mosi <= sh[15];
            cnt <= CW'(HALF - 1); st <= F_LOW;
          end
        end else cnt <= cnt - 1'b1;
        default: st <= F_IDLE;
      endcase
    end
  end

  // R2
  clk_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk);
  // R5
  cs_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |=> sclk);
endmodule

// File: rtl/regseq_access.sv
module regseq_access #(
  parameter int HALF    = 50,
  parameter int SETUP_T = 100,
  parameter int STALL_T = 2000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        go,
  input  logic        wr,
  input  logic [7:0]  addr,
  input  logic [15:0] wdata,
  output logic        ack,
  output logic [15:0] rdata,
  output logic        cs_n,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  import regseq_pkg::*;
  localparam int SW = $clog2(STALL_T + 1);

  acc_state_t   st;
  logic [SW-1:0] gap;
  logic         f_start, f_done;
  logic [15:0]  f_tx, f_rx, second;
  logic [7:0]   addr_next;

  assign addr_next = addr + 8'd1;

  regseq_frame #(.HALF(HALF), .SETUP_T(SETUP_T)) u_frame (
    .clk(clk), .rst(rst), .start(f_start), .tx(f_tx), .done(f_done),
    .rx(f_rx), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= A_IDLE; ack <= 1'b0; rdata <= '0; gap <= '0;
      f_start <= 1'b0; f_tx <= '0; second <= '0;
    end else begin
      ack <= 1'b0;
      f_start <= 1'b0;
      unique case (st)
        A_IDLE: if (go) begin
          f_tx    <= wr ? {1'b1, addr[6:0], wdata[7:0]} : {addr, 8'h00};
          second  <= wr ? {1'b1, addr_next[6:0], wdata[15:8]} : 16'h0000;
          f_start <= 1'b1; st <= A_F1;
        end
        A_F1: if (f_done) begin gap <= SW'(STALL_T - 1); st <= A_G1; end
        A_G1: if (gap == '0) begin
          f_tx <= second; f_start <= 1'b1; st <= A_F2;
        end else gap <= gap - 1'b1;
        A_F2: if (f_done) begin
          rdata <= f_rx; gap <= SW'(STALL_T - 1); st <= A_G2;
        end
        A_G2: if (gap == '0) begin ack <= 1'b1; st <= A_IDLE; end
              else gap <= gap - 1'b1;
        default: st <= A_IDLE;
      endcase
    end
  end

  // R4
  no_start_in_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (st == A_G1 || st == A_G2) |-> cs_n);
endmodule

// File: rtl/imu_regseq.sv
module imu_regseq #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int SCLK_HALF   = 50,
  parameter int CS_SETUP_US = 1,
  parameter int STALL_US    = 20,
  parameter int RST_LOW_US  = 10_000,
  parameter int RST_WAIT_US = 310_000,
  parameter int SELFTEST_US = 24_000,
  parameter int CFG_WAIT_US = 200
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        boot_req,
  input  logic        cmd_valid,
  input  logic        cmd_write,
  input  logic [7:0]  cmd_addr,
  input  logic [15:0] cmd_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        sen_rst_n,
  output logic        sen_cs_n,
  output logic        sen_sclk,
  output logic        sen_mosi,
  input  logic        sen_miso
);
  import regseq_pkg::*;
  localparam int TPU        = CLK_HZ / 1_000_000;
  localparam int SETUP_T    = CS_SETUP_US * TPU;
  localparam int STALL_T    = STALL_US * TPU;
  localparam int RST_LOW_T  = RST_LOW_US * TPU;
  localparam int RST_WAIT_T = RST_WAIT_US * TPU;
  localparam int SELFTEST_T = SELFTEST_US * TPU;
  localparam int CFG_T      = CFG_WAIT_US * TPU;
  localparam int M1 = (RST_LOW_T > RST_WAIT_T) ? RST_LOW_T : RST_WAIT_T;
  localparam int M2 = (SELFTEST_T > CFG_T) ? SELFTEST_T : CFG_T;
  localparam int WW = $clog2(((M1 > M2) ? M1 : M2) + 1);

  seq_state_t    st;
  logic [WW-1:0] wcnt;
  logic          go, wr, ack;
  logic [7:0]    addr;
  logic [15:0]   wdata, acc_rdata;

  regseq_access #(.HALF(SCLK_HALF), .SETUP_T(SETUP_T), .STALL_T(STALL_T)) u_acc (
    .clk(clk), .rst(rst), .go(go), .wr(wr), .addr(addr), .wdata(wdata),
    .ack(ack), .rdata(acc_rdata), .cs_n(sen_cs_n), .sclk(sen_sclk),
    .mosi(sen_mosi), .miso(sen_miso));

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; sen_rst_n <= 1'b1; done <= 1'b0; go <= 1'b0;
      wr <= 1'b0; addr <= '0; wdata <= '0; wcnt <= '0; rdata <= '0;
    end else begin
      done <= 1'b0;
      go   <= 1'b0;
      unique case (st)
        S_IDLE:
          if (boot_req) begin
            sen_rst_n <= 1'b0; wcnt <= WW'(RST_LOW_T - 1); st <= S_RLO;
          end else if (cmd_valid) begin
            go <= 1'b1; wr <= cmd_write; addr <= cmd_addr; wdata <= cmd_wdata;
            st <= S_CMD;
          end
        S_CMD: if (ack) begin rdata <= acc_rdata; done <= 1'b1; st <= S_IDLE; end
        S_RLO:
          if (wcnt == '0) begin
            sen_rst_n <= 1'b1; wcnt <= WW'(RST_WAIT_T - 1); st <= S_RWAIT;
          end else wcnt <= wcnt - 1'b1;
        S_RWAIT:
          if (wcnt == '0) begin
            go <= 1'b1; wr <= 1'b0; addr <= ADDR_PROD_ID; st <= S_ID;
          end else wcnt <= wcnt - 1'b1;
        S_ID: if (ack) begin
          if (acc_rdata == PROD_ID_VALUE) begin
            go <= 1'b1; wr <= 1'b1; addr <= ADDR_GLOBAL; wdata <= SELFTEST_WORD;
            st <= S_STW;
          end else begin
            sen_rst_n <= 1'b0; wcnt <= WW'(RST_LOW_T - 1); st <= S_RLO;
          end
        end
        S_STW: if (ack) begin wcnt <= WW'(SELFTEST_T - 1); st <= S_STWAIT; end
        S_STWAIT:
          if (wcnt == '0) begin
            go <= 1'b1; wr <= 1'b0; addr <= ADDR_STATUS; st <= S_STRD;
          end else wcnt <= wcnt - 1'b1;
        S_STRD: if (ack) begin
          go <= 1'b1; wr <= 1'b1;
          if (acc_rdata[SELFTEST_FAIL]) begin
            addr <= ADDR_GLOBAL; wdata <= SELFTEST_WORD; st <= S_STW;
          end else begin
            addr <= ADDR_FILTER; wdata <= '0; st <= S_CFG1;
          end
        end
        S_CFG1: if (ack) begin
          go <= 1'b1; wr <= 1'b1; addr <= ADDR_DECIM; wdata <= '0; st <= S_CFG2;
        end
        S_CFG2: if (ack) begin wcnt <= WW'(CFG_T - 1); st <= S_CFGWAIT; end
        S_CFGWAIT:
          if (wcnt == '0) begin done <= 1'b1; st <= S_IDLE; end
          else wcnt <= wcnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R6
  cs_idle_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !sen_rst_n |-> sen_cs_n);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/sim_imu_regseq.sv
module sim_imu_regseq;
  localparam int STALL = 20, SETUP = 2, RLOW = 10, RWAIT = 31, STW = 24, CFGW = 20;

  logic clk = 1'b0, rst = 1'b1;
  logic boot_req = 0, cmd_valid = 0, cmd_write = 0;
  logic [7:0] cmd_addr = 0;
  logic [15:0] cmd_wdata = 0;
  logic busy, done, sen_rst_n, sen_cs_n, sen_sclk, sen_mosi;
  logic sen_miso = 1'b0;
  logic [15:0] rdata;

  imu_regseq #(.CLK_HZ(1_000_000), .SCLK_HALF(2), .CS_SETUP_US(SETUP),
    .STALL_US(STALL), .RST_LOW_US(RLOW), .RST_WAIT_US(RWAIT),
    .SELFTEST_US(STW), .CFG_WAIT_US(CFGW)) u0 (
    .clk(clk), .rst(rst), .boot_req(boot_req), .cmd_valid(cmd_valid),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .rdata(rdata), .sen_rst_n(sen_rst_n),
    .sen_cs_n(sen_cs_n), .sen_sclk(sen_sclk), .sen_mosi(sen_mosi),
    .sen_miso(sen_miso));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // sensor model and frame log
  logic [7:0]  mem [256];
  logic [15:0] f_word [256];
  int f_fall [256], f_rise [256], f_clk1 [256];
  int nf = 0, cyc = 0, nrst = 0, rst_len = 0, rst_rise = 0;
  int id_bad = 1, st_bad = 1;
  logic p_cs = 1, p_sclk = 1, p_rst = 1, got = 0, rd_phase = 0;
  logic [15:0] sh = 0, outw = 0, pending = 0;

  function automatic logic [15:0] lookup(input logic [7:0] a);
    if (a == 8'h72 && id_bad > 0) begin id_bad--; return 16'h1234; end
    if (a == 8'h02 && st_bad > 0) begin st_bad--; return 16'h0020; end
    return {mem[8'(a + 1)], mem[a]};
  endfunction

  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  initial begin #1; mem[8'h72] = 8'h79; mem[8'h73] = 8'h40; end

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (p_rst && !sen_rst_n) begin nrst++; rst_len = 0; end
      if (!sen_rst_n) rst_len++;
      if (!p_rst && sen_rst_n) rst_rise = cyc;
      if (p_cs && !sen_cs_n) begin f_fall[nf] = cyc; outw = pending; got = 0; end
      if (!sen_cs_n && p_sclk && !sen_sclk) begin
        if (!got) begin f_clk1[nf] = cyc; got = 1; end
        sen_miso = outw[15]; outw = {outw[14:0], 1'b0};
      end
      if (!sen_cs_n && !p_sclk && sen_sclk) sh = {sh[14:0], sen_mosi};
      if (!p_cs && sen_cs_n) begin
        f_rise[nf] = cyc; f_word[nf] = sh;
        if (sh[15]) mem[{1'b0, sh[14:8]}] = sh[7:0];
        else if (!rd_phase) begin pending = lookup(sh[15:8]); rd_phase = 1; end
        else rd_phase = 0;
        if (nf < 255) nf++;
      end
    end
    p_cs = sen_cs_n; p_sclk = sen_sclk; p_rst = sen_rst_n;
  end

  function automatic logic [15:0] wlo(input logic [7:0] a, input logic [15:0] d);
    return 16'h8000 | (16'(a & 8'h7F) << 8) | 16'(d & 16'h00FF);
  endfunction
  function automatic logic [15:0] whi(input logic [7:0] a, input logic [15:0] d);
    return 16'h8000 | (16'((a + 8'd1) & 8'h7F) << 8) | (d >> 8);
  endfunction

  bit finished = 0;
  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic wait_done(output int c);
    int n = 0;
    do begin @(negedge clk); n++; end while (!done && n < 20000);
    if (!done) chk(0, "R10", "done timeout", n, 0);
    c = cyc;
  endtask

  task automatic do_cmd(input bit w, input logic [7:0] a, input logic [15:0] d,
                        output int c);
    @(negedge clk);
    cmd_valid = 1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 0;
    wait_done(c);
  endtask

  initial begin
    #(4 * 150000);
    chk(0, "R10", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    int c, bad, mn, n0, dcyc;
    logic [15:0] exp [18];
    logic [15:0] dv [8];
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(sen_rst_n && sen_cs_n && sen_sclk && !busy && !done, "R1", "idle outputs",
        {sen_rst_n, sen_cs_n, sen_sclk, busy, done}, 5'b11100);

    // bring-up with one bad identity and one failed self-test
    boot_req = 1; @(negedge clk); boot_req = 0;
    chk(busy, "R10", "busy after boot request", busy, 1);
    wait_done(dcyc);
    chk(!busy, "R10", "busy low with done", busy, 0);
    @(negedge clk);
    chk(!done, "R10", "done one cycle", done, 0);

    chk(nrst == 2, "R7", "reset pulses", nrst, 2);
    chk(rst_len == RLOW, "R6", "reset low length", rst_len, RLOW);
    chk(f_fall[2] - rst_rise >= RWAIT, "R6", "settle before first frame",
        f_fall[2] - rst_rise, RWAIT);
    exp[0] = 16'h7200; exp[1] = 0; exp[2] = 16'h7200; exp[3] = 0;
    exp[4] = wlo(8'h68, 16'h4); exp[5] = whi(8'h68, 16'h4);
    exp[6] = 16'h0200; exp[7] = 0;
    exp[8] = wlo(8'h68, 16'h4); exp[9] = whi(8'h68, 16'h4);
    exp[10] = 16'h0200; exp[11] = 0;
    exp[12] = wlo(8'h5C, 0); exp[13] = whi(8'h5C, 0);
    exp[14] = wlo(8'h64, 0); exp[15] = whi(8'h64, 0);
    chk(nf == 16, "R8", "bring-up frame count", nf, 16);
    bad = 0;
    for (int i = 0; i < 16; i++) if (f_word[i] != exp[i]) bad++;
    chk(bad == 0, "R7", "bring-up frame words R8 R9", bad, 0);
    chk(f_fall[6] - f_rise[5] >= STALL + STW, "R8", "self-test wait 1",
        f_fall[6] - f_rise[5], STALL + STW);
    chk(f_fall[10] - f_rise[9] >= STALL + STW, "R8", "self-test wait 2",
        f_fall[10] - f_rise[9], STALL + STW);
    chk(dcyc - f_rise[15] >= STALL + CFGW, "R9", "config settle",
        dcyc - f_rise[15], STALL + CFGW);

    // write then read-back sweep
    for (int i = 0; i < 8; i++) begin
      logic [7:0] a;
      a = 8'(8'h10 + 2 * i);
      dv[i] = 16'(i * 16'h2345 + 16'h1001);
      do_cmd(1, a, dv[i], c);
      chk(f_word[nf-2] == wlo(a, dv[i]) && f_word[nf-1] == whi(a, dv[i]), "R3",
          "write frames", f_word[nf-2], wlo(a, dv[i]));
      do_cmd(0, a, 16'hFFFF, c);
      chk(f_word[nf-2] == {a, 8'h00} && f_word[nf-1] == 16'h0000, "R2",
          "read frames", f_word[nf-2], {a, 8'h00});
      chk(rdata == dv[i], "R2", "read-back data", rdata, dv[i]);
    end
    do_cmd(0, 8'h11, 16'h0, c);
    chk(rdata == {dv[1][7:0], dv[0][15:8]}, "R3", "byte split across addresses",
        rdata, {dv[1][7:0], dv[0][15:8]});

    // command while busy is ignored
    n0 = nf;
    @(negedge clk);
    cmd_valid = 1; cmd_write = 1; cmd_addr = 8'h20; cmd_wdata = 16'hAAAA;
    @(negedge clk);
    cmd_addr = 8'h22; cmd_wdata = 16'h5555;
    repeat (10) @(negedge clk);
    cmd_valid = 0;
    wait_done(c);
    chk(nf - n0 == 2, "R10", "frames for overlapped request", nf - n0, 2);
    do_cmd(0, 8'h22, 16'h0, c);
    chk(rdata == 16'h0000, "R10", "ignored write left register", rdata, 0);
    do_cmd(0, 8'h20, 16'h0, c);
    chk(rdata == 16'hAAAA, "R3", "accepted write", rdata, 16'hAAAA);

    // whole-log timing
    mn = 1000000;
    for (int i = 0; i + 1 < nf; i++)
      if (f_fall[i+1] - f_rise[i] < mn) mn = f_fall[i+1] - f_rise[i];
    chk(mn >= STALL, "R4", "minimum deselect gap", mn, STALL);
    mn = 1000000;
    for (int i = 0; i < nf; i++)
      if (f_clk1[i] - f_fall[i] < mn) mn = f_clk1[i] - f_fall[i];
    chk(mn >= SETUP, "R5", "minimum select setup", mn, SETUP);
    report();
  end
endmodule